// File: doc/BRIEF.md
# Low-Frequency Modulation Source

This block produces the slow modulation state that every voice of a synthesis engine reads at the same time. A prescaler counts sample ticks and reloads after a terminal count taken from a fixed table of eight entries. The 3-bit rate field selects the entry. Each reload advances a 7-bit step counter. The step counter feeds two derived outputs:

- an amplitude-modulation level shaped as an inverted triangle;
- a coarse 5-bit phase-modulation step.

Both outputs are registered.

The caller supplies a one-clock-wide sample tick, normally once every 24 internal clocks. It also supplies a run bit and a freeze bit used for testing. While the run bit is low, the counters sit at zero. The freeze bit stops the prescaler without clearing it. How the modulation is applied to envelopes and frequencies belongs to other blocks.

Top module: `lfo_gen`

## Requirements
- R1: After reset the step counter is 0, so `am_level` reads 127 and `pm_step` reads 0.
- R2: The terminal count for rate codes 0..7 is 5 for code 7, 8 for code 6, 44 for code 5, 62 for code 4, 67 for code 3, 71 for code 2, 77 for code 1 and 108 for code 0. The prescaler counts 0 up to that value, so the step advances once every terminal+1 ticks.
- R3: The prescaler and step counter change only on clocks where `tick` is high; with `tick` low the outputs hold.
- R4: The step counter is 7 bits and wraps from 127 to 0, so a full period is 128 step advances.
- R5: While `run` is low, the prescaler and step counter are cleared and held at zero. The outputs read 127 and 0 from the next clock.
- R6: While `freeze` is high, ticks do not move the prescaler or the step. Counting resumes from the held prescaler value when `freeze` falls.
- R7: `am_level` equals the step's bits 5:0 shifted left by one, with bit 0 set to 0, XORed bitwise with the inverse of step bit 6. This gives 127 at step 0, 1 at step 63, 0 at step 64 and 126 at step 127.
- R8: `pm_step` equals step bits 6:2.
- R9: The prescaler reloads on any tick where its count is at or above the selected terminal. A rate change to a faster code therefore takes effect on the next tick, with no wrap through 127.
- R10: Both outputs are registered and reflect an advance right after the clock edge that consumed the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one clock wide |
| run | input | 1 | Run bit; low clears and holds counters |
| freeze | input | 1 | Test freeze of the prescaler |
| rate | input | 3 | Rate code selecting the terminal count |
| am_level | output | 7 | Inverted-triangle amplitude level |
| pm_step | output | 5 | Phase-modulation step, 0..31 |

## Verification
Several of the block's functions can fall in the same cycle:

- a terminal-count tick can arrive on the very clock where `run` drops, where `freeze` rises, or where `rate` switches to a shorter terminal;
- the 127-to-0 wrap can coincide with any of these.

Random stimulus is weighted toward the two shortest terminal counts, with frequent rate changes and sparse `run`/`freeze` pulses, so these overlaps occur many times. Each clock the outputs are compared against a bench model built from the requirements, in which clearing dominates freezing and freezing dominates counting. Directed sequences place a rate switch and a freeze release on exact tick counts and check the recovered step value.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

   localparam int unsigned RATE_W     = 3;
   localparam int unsigned NUM_RATES  = 1 << RATE_W;
   localparam int unsigned TERM_W     = 7;

   // Terminal tick counts per rate code; reload happens at count >= value.
   function automatic logic [TERM_W-1:0] rate_terminal(input logic [RATE_W-1:0] code);
      logic [TERM_W-1:0] t;
      case (code)
         3'd0:    t = 7'd108;
         3'd1:    t = 7'd77;
         3'd2:    t = 7'd71;
         3'd3:    t = 7'd67;
         3'd4:    t = 7'd62;
         3'd5:    t = 7'd44;
         3'd6:    t = 7'd8;
         default: t = 7'd5;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/lfo_prescaler.sv
module lfo_prescaler #(
   parameter int unsigned PRE_W = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      freeze,
   input  logic                      tick,
   input  logic [lfo_pkg::RATE_W-1:0] rate,
   output logic                      adv
);

   localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

   generate
      if (PRE_W < lfo_pkg::TERM_W) begin : g_bad_width
         $error("lfo_prescaler: PRE_W must hold the largest terminal count");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] term_w;
   logic             live_tick;
   logic             at_term;

   assign term_w    = PRE_W'(lfo_pkg::rate_terminal(rate));
   assign live_tick = run & tick & ~freeze;
   assign at_term   = (cnt_q >= term_w);
   assign adv       = live_tick & at_term;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (live_tick) begin
         if (at_term) cnt_q <= '0;
         else         cnt_q <= cnt_q + ONE;
      end
   end

   // R5: run low clears the prescaler
   a_r5_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

   // R6: freeze keeps the prescaler value
   a_r6_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run && freeze) |=> $stable(cnt_q));

   // R3: no tick, no motion
   a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q));

   // R9: a reload never leaves the count above zero
   a_r9_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt_q == '0));

endmodule

// File: rtl/lfo_step_ctr.sv
module lfo_step_ctr #(
   parameter int unsigned STEP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   output logic [STEP_W-1:0] step_q,
   output logic [STEP_W-1:0] step_d
);

   localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

   generate
      if (STEP_W < 2) begin : g_bad_width
         $error("lfo_step_ctr: STEP_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (!rst_n || !run) step_d = '0;
      else if (adv)       step_d = step_q + ONE;
      else                step_d = step_q;
   end

   always_ff @(posedge clk) begin
      step_q <= step_d;
   end

   // R5: run low holds the step at zero
   a_r5_step_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (step_q == '0));

   // R4: an advance adds exactly one, modulo the width
   a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (run && adv) |=> (step_q == STEP_W'($past(step_q) + ONE)));

   // R2: without an advance the step is steady
   a_r2_step_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv) |=> $stable(step_q));

endmodule

// File: rtl/lfo_shaper.sv
module lfo_shaper #(
   parameter int unsigned STEP_W = 7,
   parameter int unsigned PM_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step_d,
   output logic [STEP_W-1:0] am_q,
   output logic [PM_W-1:0]   pm_q
);

   localparam int unsigned MSB = STEP_W - 1;

   generate
      if (PM_W > STEP_W) begin : g_bad_pm
         $error("lfo_shaper: PM_W cannot exceed STEP_W");
      end
   endgenerate

   logic [STEP_W-1:0] am_d;
   logic [PM_W-1:0]   pm_d;
   logic              fold;

   assign fold    = ~step_d[MSB];
   assign am_d[0] = fold;

   generate
      for (genvar i = 1; i < STEP_W; i++) begin : g_fold
         assign am_d[i] = step_d[i-1] ^ fold;
      end
   endgenerate

   assign pm_d = step_d[MSB -: PM_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         am_q <= '1;
         pm_q <= '0;
      end else begin
         am_q <= am_d;
         pm_q <= pm_d;
      end
   end

endmodule

// File: rtl/lfo_gen.sv
module lfo_gen #(
   parameter int unsigned PRE_W  = 7,
   parameter int unsigned STEP_W = 7,
   parameter int unsigned PM_W   = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic                      run,
   input  logic                      freeze,
   input  logic [lfo_pkg::RATE_W-1:0] rate,
   output logic [STEP_W-1:0]         am_level,
   output logic [PM_W-1:0]           pm_step
);

   logic              adv;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] step_d;

   lfo_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .freeze (freeze),
      .tick   (tick),
      .rate   (rate),
      .adv    (adv)
   );

   lfo_step_ctr #(.STEP_W(STEP_W)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .adv    (adv),
      .step_q (step_q),
      .step_d (step_d)
   );

   lfo_shaper #(.STEP_W(STEP_W), .PM_W(PM_W)) u_shape (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_d (step_d),
      .am_q   (am_level),
      .pm_q   (pm_step)
   );

   // R10: outputs move only on an advance or a clear
   a_r10_out_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv) |=> ($stable(am_level) && $stable(pm_step)));

   // R8: phase step follows the counter's upper bits
   a_r8_pm_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pm_step == step_q[STEP_W-1 -: PM_W]));

endmodule

// File: tb/lfo_gen_tb_top.sv
`timescale 1ns/1ps
module lfo_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       run = 1'b0;
   logic       freeze = 1'b0;
   logic [2:0] rate = 3'd7;
   logic [6:0] am_level;
   logic [4:0] pm_step;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;
   int mc = 0;
   int ms = 0;

   always #5 clk = ~clk;

   lfo_gen dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .freeze(freeze),
      .rate(rate), .am_level(am_level), .pm_step(pm_step)
   );

   function automatic int term_of(input logic [2:0] c);
      case (c)
         3'd0: return 108;  3'd1: return 77;  3'd2: return 71;  3'd3: return 67;
         3'd4: return 62;   3'd5: return 44;  3'd6: return 8;   default: return 5;
      endcase
   endfunction

   function automatic int am_of(input int s);
      logic [6:0] st;
      st = 7'(s);
      return int'({st[5:0], 1'b0} ^ {7{~st[6]}});
   endfunction

   function automatic int step_from_am(input logic [6:0] a);
      logic s6;
      s6 = ~a[0];
      return int'({s6, a[6:1] ^ {6{~s6}}});
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Requirement model, updated at the edge the DUT uses
   always @(posedge clk) begin
      if (!rst_n || !run) begin
         mc = 0; ms = 0;
      end else if (tick && !freeze) begin
         if (mc >= term_of(rate)) begin
            mc = 0; ms = (ms + 1) % 128;
         end else mc = mc + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 am_level", int'(am_level), am_of(ms));
         chk("R8 pm_step", int'(pm_step), ms / 4);
      end
   end

   task automatic ticks_exact(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic restart();
      @(negedge clk); run = 1'b0;
      @(negedge clk); run = 1'b1;
   endtask

   initial begin
      void'($urandom(32'h5EED_1F0));
      repeat (3) @(negedge clk);
      chk("R1 am_level reset", int'(am_level), 127);
      chk("R1 pm_step reset", int'(pm_step), 0);
      rst_n = 1'b1;
      @(negedge clk); run = 1'b1; rate = 3'd7;

      ticks_exact(5);
      chk("R2 no advance before terminal+1", step_from_am(am_level), 0);
      ticks_exact(1);
      chk("R2/R10 advance after 6 ticks", step_from_am(am_level), 1);
      ticks_exact(6 * 127);
      chk("R4 wrap to zero after 128 steps", step_from_am(am_level), 0);
      ticks_exact(6 * 64);
      chk("R7 am at step 64", int'(am_level), 0);
      ticks_exact(6 * 63);
      chk("R7 am at step 127", int'(am_level), 126);

      @(negedge clk); run = 1'b0;
      @(negedge clk);
      chk("R5 am cleared", int'(am_level), 127);
      chk("R5 pm cleared", int'(pm_step), 0);
      ticks_exact(20);
      chk("R5 held while run low", step_from_am(am_level), 0);

      @(negedge clk); run = 1'b1; rate = 3'd6;
      ticks_exact(5);
      @(negedge clk); freeze = 1'b1;
      ticks_exact(50);
      chk("R6 frozen step", step_from_am(am_level), 0);
      @(negedge clk); freeze = 1'b0;
      ticks_exact(3);
      chk("R6 not yet after resume", step_from_am(am_level), 0);
      ticks_exact(1);
      chk("R6 resumed count", step_from_am(am_level), 1);

      restart(); rate = 3'd0;
      ticks_exact(100);
      chk("R9 slow rate no advance", step_from_am(am_level), 0);
      @(negedge clk); rate = 3'd7;
      ticks_exact(1);
      chk("R9 fast rate reloads at once", step_from_am(am_level), 1);
      repeat (40) @(negedge clk);
      chk("R3 no tick no advance", step_from_am(am_level), 1);

      restart(); rate = 3'd0;
      ticks_exact(109 * 4);
      chk("R2 rate 0 four steps", step_from_am(am_level), 4);
      chk("R8 pm at step 4", int'(pm_step), 1);

      restart(); rate = 3'd2;
      ticks_exact(72 * 8);
      chk("R8 pm at step 8", int'(pm_step), 2);

      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         tick   = ($urandom % 100) < 70;
         run    = ($urandom % 100) < 98;
         freeze = ($urandom % 100) < 5;
         if (($urandom % 100) < 2)
            rate = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'(6 + $urandom % 2);
      end

      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #1_900_000;
      if (!done) begin
         done = 1'b1;
         errs++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule